// File: doc/BRIEF.md
# Rank-Preserving Frequency Equalizer

This block takes a set of ring-oscillator count values and rewrites each one as an evenly spaced level, while every oscillator keeps its rank in the set. Software or an upstream collector writes the counts one per cycle, each with an index, over a valid/ready port. A start pulse then freezes the set. The block ranks every entry and works out a uniform step from the spread between the smallest and largest counts. It then assigns each entry the level of its rank. Equalizing the gaps this way keeps later pairwise-difference features from shifting when temperature stretches the spacing between oscillators unevenly.

The results are unsigned fixed point with `FRAC` fraction bits. They leave in the original index order, one per cycle, and a single-cycle done flag follows the last one. The smallest count comes back exactly. The largest comes back to within the rounding of the step.

Top module: `freq_equalizer`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid` and `done` are 0.
- R2: While `in_ready` is 1, a cycle with `in_valid` high stores `in_val` at position `in_idx`. A later write to the same index replaces the earlier value.
- R3: From the cycle after an accepted start until `done` has been raised, `in_ready` is 0. Inputs offered in that window do not change any result.
- R4: When a write and `start` occur in the same cycle, the write is taken and its value is part of the set being equalized.
- R5: An entry's rank is the number of entries that are strictly smaller than it, plus the number that are equal and have a lower index. Equal counts therefore rank in ascending index order.
- R6: The step is floor((max − min) · 2^FRAC / (N − 1)), where min and max are the smallest and largest inputs.
- R7: The entry of rank 0 outputs exactly min · 2^FRAC.
- R8: The entry of rank N−1 outputs a value that is never above max · 2^FRAC and no more than N−1 LSBs below it.
- R9: Every output equals min · 2^FRAC + rank · step, with `FRAC` fraction bits.
- R10: The outputs arrive on N consecutive cycles with `out_idx` running 0, 1, …, N−1. `done` is high for the single cycle after the last output.
- R11: If all inputs are equal, the step is 0 and every output equals that value · 2^FRAC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A count is offered |
| in_ready | output | 1 | The block accepts counts (idle) |
| in_idx | input | $clog2(N) | Position of the offered count |
| in_val | input | W | Offered count value |
| start | input | 1 | Begin equalizing the stored set |
| out_valid | output | 1 | An equalized level is present |
| out_idx | output | $clog2(N) | Position of the present level |
| out_val | output | W+FRAC | Equalized level, FRAC fraction bits |
| done | output | 1 | Single-cycle pulse after the last level |

## Verification
A count write and the start pulse can fall in the same cycle. The bench drives the last index of a set together with `start`. It judges the case by checking that the equalized levels, and the minimum and maximum they imply, include that final count (R4). Acceptance and the busy state also meet right after start. The bench therefore keeps offering counts that would corrupt the set during ranking, and confirms at the outputs that none of them was taken.

// File: rtl/feq_pkg.sv
package feq_pkg;
  typedef enum logic [2:0] {
    ST_LOAD,
    ST_RANK,
    ST_DIV,
    ST_EMIT,
    ST_FIN
  } feq_state_t;
endpackage

// File: rtl/feq_ranker.sv
module feq_ranker #(
  parameter int N  = 10,
  parameter int W  = 20,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [W-1:0]  a_val,
  input  logic [W-1:0]  b_val,
  output logic [IW-1:0] a_idx,
  output logic [IW-1:0] b_idx,
  input  logic [IW-1:0] rank_sel,
  output logic [IW-1:0] rank_out,
  output logic [W-1:0]  lo,
  output logic [W-1:0]  hi,
  output logic          fin
);
  logic [IW-1:0] rank_q [N];
  logic [IW-1:0] cnt;
  logic          busy;
  logic          b_below;
  logic [IW-1:0] cnt_next;
  logic          row_end;

  // an entry ranks below another if smaller, or equal with a lower index
  always_comb begin
    b_below  = (b_val < a_val) || ((b_val == a_val) && (b_idx < a_idx));
    cnt_next = cnt + IW'(b_below);
    row_end  = (b_idx == IW'(N-1));
  end

  assign rank_out = rank_q[rank_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      fin   <= 1'b0;
      a_idx <= '0;
      b_idx <= '0;
      cnt   <= '0;
      lo    <= '0;
      hi    <= '0;
      for (int k = 0; k < N; k++) rank_q[k] <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        busy  <= 1'b1;
        a_idx <= '0;
        b_idx <= '0;
        cnt   <= '0;
        lo    <= '1;
        hi    <= '0;
      end else if (busy) begin
        if (b_val < lo) lo <= b_val;
        if (b_val > hi) hi <= b_val;
        if (row_end) begin
          rank_q[a_idx] <= cnt_next;
          cnt   <= '0;
          b_idx <= '0;
          if (a_idx == IW'(N-1)) begin
            busy <= 1'b0;
            fin  <= 1'b1;
          end else begin
            a_idx <= a_idx + 1'b1;
          end
        end else begin
          cnt   <= cnt_next;
          b_idx <= b_idx + 1'b1;
        end
      end
    end
  end

  // R5: a count never exceeds the number of other entries
  a_r5_rank_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= b_idx));
  // R6: the spread is ordered once ranking has finished
  a_r6_spread_order: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (lo <= hi));
endmodule

// File: rtl/feq_divider.sv
module feq_divider #(
  parameter int OW      = 28,
  parameter int DIVISOR = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [OW-1:0] dividend,
  output logic [OW-1:0] quo,
  output logic          fin
);
  localparam int RB = $clog2(DIVISOR + 1);
  localparam int CW = $clog2(OW + 1);
  localparam int PW = OW + RB + 1;

  logic [OW-1:0] sh;
  logic [OW-1:0] orig;
  logic [RB-1:0] rem;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [RB:0]   trial;
  logic          fits;

  always_comb begin
    trial = {rem, sh[OW-1]};
    fits  = (trial >= (RB+1)'(DIVISOR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      fin  <= 1'b0;
      sh   <= '0;
      orig <= '0;
      rem  <= '0;
      cnt  <= '0;
      quo  <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        busy <= 1'b1;
        sh   <= dividend;
        orig <= dividend;
        rem  <= '0;
        cnt  <= '0;
        quo  <= '0;
      end else if (busy) begin
        rem <= fits ? RB'(trial - (RB+1)'(DIVISOR)) : RB'(trial);
        quo <= {quo[OW-2:0], fits};
        sh  <= {sh[OW-2:0], 1'b0};
        cnt <= cnt + 1'b1;
        if (cnt == CW'(OW-1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  // R6: the quotient is the floor of dividend / DIVISOR
  a_r6_floor_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> ((PW'(quo) * PW'(DIVISOR) <= PW'(orig)) &&
             (PW'(orig) - PW'(quo) * PW'(DIVISOR) < PW'(DIVISOR))));
endmodule

// File: rtl/freq_equalizer.sv
module freq_equalizer #(
  parameter int N    = 10,
  parameter int W    = 20,
  parameter int FRAC = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [$clog2(N)-1:0]      in_idx,
  input  logic [W-1:0]              in_val,
  input  logic                      start,
  output logic                      out_valid,
  output logic [$clog2(N)-1:0]      out_idx,
  output logic [W+FRAC-1:0]         out_val,
  output logic                      done
);
  import feq_pkg::*;

  localparam int IW = $clog2(N);
  localparam int OW = W + FRAC;

  feq_state_t    state;
  logic [W-1:0]  vals [N];
  logic [IW-1:0] emit_k;

  logic [IW-1:0] rk_a_idx, rk_b_idx, rk_rank;
  logic [W-1:0]  rk_lo, rk_hi;
  logic          rk_go, rk_fin;
  logic          dv_go, dv_fin;
  logic [OW-1:0] dv_quo;
  logic [OW-1:0] spread_fx;
  logic          take_in;

  function automatic logic [OW-1:0] level_of(input logic [W-1:0]  base,
                                             input logic [IW-1:0] rnk,
                                             input logic [OW-1:0] st);
    return (OW'(base) << FRAC) + OW'(rnk) * st;
  endfunction

  assign in_ready  = (state == ST_LOAD);
  assign take_in   = in_valid && in_ready && (in_idx < IW'(N));
  assign rk_go     = (state == ST_LOAD) && start;
  assign dv_go     = rk_fin;
  assign spread_fx = OW'(rk_hi - rk_lo) << FRAC;

  feq_ranker #(.N(N), .W(W), .IW(IW)) u_rank (
    .clk(clk), .rst_n(rst_n), .go(rk_go),
    .a_val(vals[rk_a_idx]), .b_val(vals[rk_b_idx]),
    .a_idx(rk_a_idx), .b_idx(rk_b_idx),
    .rank_sel(emit_k), .rank_out(rk_rank),
    .lo(rk_lo), .hi(rk_hi), .fin(rk_fin)
  );

  feq_divider #(.OW(OW), .DIVISOR(N-1)) u_div (
    .clk(clk), .rst_n(rst_n), .go(dv_go),
    .dividend(spread_fx), .quo(dv_quo), .fin(dv_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) vals[k] <= '0;
    end else if (take_in) begin
      vals[in_idx] <= in_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_LOAD;
      emit_k    <= '0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_val   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_LOAD: begin
          out_valid <= 1'b0;
          if (start) state <= ST_RANK;
        end
        ST_RANK: if (rk_fin) state <= ST_DIV;
        ST_DIV: begin
          if (dv_fin) begin
            state  <= ST_EMIT;
            emit_k <= '0;
          end
        end
        ST_EMIT: begin
          out_valid <= 1'b1;
          out_idx   <= emit_k;
          out_val   <= level_of(rk_lo, rk_rank, dv_quo);
          if (emit_k == IW'(N-1)) state <= ST_FIN;
          else emit_k <= emit_k + 1'b1;
        end
        ST_FIN: begin
          out_valid <= 1'b0;
          done      <= 1'b1;
          state     <= ST_LOAD;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  // R3: no count is accepted while levels are being produced
  a_r3_no_load_while_out: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R8: no level exceeds the scaled maximum input
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_val <= (OW'(rk_hi) << FRAC)));
  // R10: indices advance by one on back-to-back outputs
  a_r10_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_idx == $past(out_idx) + 1'b1));
  // R10: done follows directly on the last index
  a_r10_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(out_valid) && ($past(out_idx) == IW'(N-1)) && !out_valid));
endmodule

// File: tb/sim_freq_equalizer.sv
module sim_freq_equalizer;
  localparam int N    = 10;
  localparam int W    = 20;
  localparam int FRAC = 8;
  localparam int IW   = $clog2(N);
  localparam int OW   = W + FRAC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [IW-1:0] in_idx = '0;
  logic [W-1:0]  in_val = '0;
  logic          start = 1'b0;
  logic          out_valid;
  logic [IW-1:0] out_idx;
  logic [OW-1:0] out_val;
  logic          done;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  longint vin [N];
  longint got [N];
  longint rk  [N];

  always #2.5 clk = ~clk;

  freq_equalizer #(.N(N), .W(W), .FRAC(FRAC)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_idx(in_idx), .in_val(in_val), .start(start), .out_valid(out_valid),
    .out_idx(out_idx), .out_val(out_val), .done(done)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      finish_run();
    end
  end

  // ranks via a stable insertion order on (value, index)
  function automatic void bench_ranks();
    int ord [N];
    for (int i = 0; i < N; i++) ord[i] = i;
    for (int i = 1; i < N; i++) begin
      for (int j = i; j > 0; j--) begin
        if (vin[ord[j-1]] > vin[ord[j]]) begin
          int t = ord[j];
          ord[j] = ord[j-1];
          ord[j-1] = t;
        end
      end
    end
    for (int p = 0; p < N; p++) rk[ord[p]] = p;
  endfunction

  task automatic run_set(input bit joint_start, input bit poke_busy);
    longint mn, mx, step, lvl;
    int guard;
    // R2: a stale write to index 2 that the loop overwrites
    @(negedge clk);
    in_valid = 1'b1; in_idx = IW'(2); in_val = W'(vin[2] ^ 20'h5A5A5);
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_idx = IW'(k); in_val = W'(vin[k]);
      if (joint_start && k == N-1) start = 1'b1;  // R4 same-cycle case
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (!joint_start) begin
      start = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    if (poke_busy) begin
      for (int k = 0; k < 4; k++) begin
        in_valid = 1'b1; in_idx = IW'(k % N); in_val = '0;
        chk("R3 in_ready busy", longint'(in_ready), 0);
        @(negedge clk);
      end
      in_valid = 1'b0;
    end
    guard = 0;
    while (!out_valid && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    mn = vin[0]; mx = vin[0];
    for (int k = 1; k < N; k++) begin
      if (vin[k] < mn) mn = vin[k];
      if (vin[k] > mx) mx = vin[k];
    end
    step = ((mx - mn) << FRAC) / (N - 1);  // R6
    bench_ranks();
    for (int k = 0; k < N; k++) begin
      chk("R10 out_valid", longint'(out_valid), 1);
      chk("R10 out_idx", longint'(out_idx), k);
      got[k] = longint'(out_val);
      lvl = (mn << FRAC) + rk[k] * step;
      chk("R9 R5 level", got[k], lvl);
      @(negedge clk);
    end
    chk("R10 done", longint'(done), 1);
    chk("R10 valid low", longint'(out_valid), 0);
    for (int k = 0; k < N; k++) begin
      if (rk[k] == 0) chk("R7 min exact", got[k], mn << FRAC);
      if (rk[k] == N-1) begin
        chk("R8 not above max", longint'(got[k] <= (mx << FRAC)), 1);
        chk("R8 within N-1 LSB", longint'((mx << FRAC) - got[k] <= N-1), 1);
      end
    end
    @(negedge clk);
    chk("R10 done single", longint'(done), 0);
    chk("R3 ready back", longint'(in_ready), 1);
  endtask

  initial begin
    void'($urandom(32'h1F0C5));
    repeat (3) @(negedge clk);
    chk("R1 in_ready", longint'(in_ready), 1);
    chk("R1 out_valid", longint'(out_valid), 0);
    chk("R1 done", longint'(done), 0);
    rst_n = 1'b1;

    // directed spread of oscillator-like counts
    vin = '{434405, 433389, 440266, 437535, 434414,
            433264, 443898, 436520, 433556, 434452};
    run_set(1'b0, 1'b0);
    // R11: all equal
    for (int k = 0; k < N; k++) vin[k] = 500;
    run_set(1'b0, 1'b0);
    for (int k = 0; k < N; k++) chk("R11 flat", got[k], 500 << FRAC);
    // R5: ties resolved by index
    vin = '{7, 3, 7, 3, 9, 3, 7, 9, 1, 7};
    run_set(1'b0, 1'b0);
    // R4: last write together with start; the last value is the unique max
    vin = '{10, 20, 30, 40, 50, 60, 70, 80, 90, 1000};
    run_set(1'b1, 1'b0);
    chk("R4 joint write max", got[N-1], 1000 << FRAC);
    // R3: pokes while busy; index 0 holds the unique minimum
    vin = '{5, 100, 200, 300, 400, 500, 600, 700, 800, 900};
    run_set(1'b0, 1'b1);
    chk("R3 pokes ignored", got[0], 5 << FRAC);
    // full range
    vin = '{0, 1048575, 3, 77, 1048575, 0, 500000, 12, 99999, 654321};
    run_set(1'b1, 1'b1);
    // random sets, some narrow to force ties
    for (int r = 0; r < 24; r++) begin
      int base = $urandom_range(0, 1000000);
      int span = (r % 3 == 0) ? 3 : $urandom_range(1, 48000);
      for (int k = 0; k < N; k++) vin[k] = base + $urandom_range(0, span);
      run_set(r[0], r[1]);
    end
    finish_run();
  end
endmodule